// File: doc/BRIEF.md
# Rate-Limited Link Recovery Sequencer

This block decides when a network node may try to rejoin its bus after it has dropped out because of a thermal trip or a bus-off. It first holds the node until a cooling gate opens. It then admits reconnect attempts only when three limiters all agree: an exponential backoff timer, a cap on attempts inside a sliding time window, and a token bucket. These limits stop a node from heating itself again through a storm of rapid retries.

Each attempt walks through staged rejoin: it first records the error counter as a baseline, then observes the bus silently, then transmits in a limited way, and only then returns to normal operation. An attempt fails if the error counter rises above the baseline or a bus-off arrives during these stages. Each failure pushes the node one level down a de-rate ladder. The levels are full operation, reduced speed, reduced speed plus reduced drive, receive-only, and finally isolation. The level climbs back one step at a time while the node stays online without errors.

The controller has six states. ONLINE is normal service. COOLING waits for the gate. BACKOFF waits for the backoff timer and the limiters. OBSERVE is silent observation. LIMITED is restricted transmit. ISOLATED is the terminal shutdown state. The transitions are:
- ONLINE→COOLING on a bus-off or a thermal event.
- COOLING→BACKOFF when the gate opens.
- BACKOFF→OBSERVE when an attempt is admitted.
- OBSERVE→LIMITED and LIMITED→ONLINE when their dwell times expire.
- OBSERVE or LIMITED→BACKOFF on a failure.
- OBSERVE or LIMITED→ISOLATED on a failure taken at the receive-only level.

All time is counted in pulses of a one-second tick input.

Top module: `link_recovery_seq`

## Requirements
- R1: In COOLING the gate opens when `temp_code` < TEMP_OK (default 90) and `temp_rising` is 0, or when WAIT_S+HOLD_S ticks (default 5+3=8) have been counted in COOLING; the next cycle the state becomes BACKOFF.
- R2: The backoff is 1 s after reset and after a successful rejoin. It doubles on each failed attempt and saturates at BO_CAP_S (default 8). It is reported on `backoff_s`.
- R3: An attempt is admitted only while fewer than WIN_CAP (default 3) attempts lie within the last WIN_MIN×60 ticks (default 60). An attempt stops counting on the 60th tick after it was taken.
- R4: The token bucket starts full at TOK_MAX (default 4). It gains REFILL_PM per 60 ticks (default 6, i.e. one token every 10 ticks) and saturates at TOK_MAX. Each attempt costs TOK_COST (default 2). An attempt is blocked while `tokens` < TOK_COST.
- R5: Each failed attempt raises `level` by one. Level 1 sets `speed_low`. Level 2 adds `drive_low`. Level 3 sets `listen_only` (together with `speed_low` and `drive_low`). Level 4 sets `isolate`. `retry_idx` counts the failed attempts since the last successful rejoin.
- R6: While ONLINE at levels 1 to 3, `level` drops by one after STABLE_S (default 10) consecutive ticks with no rise of `err_cnt`. A rise restarts the count.
- R7: When an attempt is admitted the state goes to OBSERVE and the current `err_cnt` is kept as a baseline. After OBS_S (default 2) ticks the state goes to LIMITED (`tx_en`=1, `tx_limited`=1). After LIM_S (default 2) ticks it goes to ONLINE. `tx_en` is 1 only in ONLINE or LIMITED below level 3.
- R8: In OBSERVE or LIMITED, `err_cnt` above the baseline or a `bus_off` pulse aborts the attempt and returns the state to BACKOFF the next cycle.
- R9: After reset the state is ONLINE (`state_code` 0) at level 0 with `tx_en`=1. In ONLINE a `bus_off` or `thermal_evt` pulse moves the state to COOLING (`state_code` 1) and drops `tx_en`.
- R10: A failure at level 3 enters ISOLATED (`state_code` 5, level 4). ISOLATED is left only by reset. The state codes are BACKOFF=2, OBSERVE=3 and LIMITED=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| temp_code | input | TEMP_W | Temperature reading |
| temp_rising | input | 1 | 1 while temperature slope is positive |
| bus_off | input | 1 | Bus-off event pulse |
| thermal_evt | input | 1 | Thermal trip event pulse |
| err_cnt | input | ERR_W | Current bus error counter value |
| speed_low | output | 1 | Reduced bit rate requested |
| drive_low | output | 1 | Reduced driver strength requested |
| listen_only | output | 1 | Receive-only mode |
| isolate | output | 1 | Node disconnected |
| tx_en | output | 1 | Transmit permitted |
| tx_limited | output | 1 | Transmit restricted (rejoin stage) |
| state_code | output | 3 | Controller state |
| level | output | 3 | De-rate level 0..4 |
| retry_idx | output | RETRY_W | Failed attempts in this episode |
| backoff_s | output | BO_W | Current backoff in seconds |
| tokens | output | TOK_W | Tokens in the bucket |

## Verification
A corrupted backoff, token or window register shows at the ports as an attempt that starts a tick too early or too late. `state_code` is one tick off the BACKOFF→OBSERVE moment predicted from the tick count. `tokens` also shows a wrong value on the cycle after the take. A wrong ladder or baseline register shows up on the first cycle after a failure or a stable window: `level` and the mode outputs differ at once. A stale baseline makes a constant non-zero error count abort a rejoin that should finish. The tests therefore stop exactly on the tick where each limiter should release or block, so any of these faults differs at the ports within one tick.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_ONLINE   = 3'd0,
        ST_COOLING  = 3'd1,
        ST_BACKOFF  = 3'd2,
        ST_OBSERVE  = 3'd3,
        ST_LIMITED  = 3'd4,
        ST_ISOLATED = 3'd5
    } rec_state_e;

    localparam logic [2:0] LVL_FULL   = 3'd0;
    localparam logic [2:0] LVL_SLOW   = 3'd1;
    localparam logic [2:0] LVL_WEAK   = 3'd2;
    localparam logic [2:0] LVL_LISTEN = 3'd3;
    localparam logic [2:0] LVL_OFF    = 3'd4;

endpackage

// File: rtl/lrs_cool_gate.sv
module lrs_cool_gate #(
    parameter int TEMP_W  = 8,
    parameter int TEMP_OK = 90,
    parameter int WAIT_S  = 5,
    parameter int HOLD_S  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [TEMP_W-1:0] temp,
    input  logic              rising,
    output logic              pass
);
    localparam int TOTAL = WAIT_S + HOLD_S;
    localparam int TM_W  = $clog2(TOTAL + 1);

    logic [TM_W-1:0] tmr;
    logic            temp_ok;
    logic            time_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr <= '0;
        else if (!en)
            tmr <= '0;
        else if (tick && (tmr != TM_W'(TOTAL)))
            tmr <= tmr + 1'b1;
    end

    always_comb begin
        temp_ok = (temp < TEMP_W'(TEMP_OK)) && !rising;
        time_ok = (tmr == TM_W'(TOTAL));
        pass    = en && (temp_ok || time_ok);
    end

    // R1: timer never runs outside the cooling phase
    p_timer_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tmr == '0));

endmodule

// File: rtl/lrs_rate_limiter.sv
module lrs_rate_limiter #(
    parameter int BO_CAP_S  = 8,
    parameter int WIN_MIN   = 1,
    parameter int WIN_CAP   = 3,
    parameter int TOK_MAX   = 4,
    parameter int TOK_COST  = 2,
    parameter int REFILL_PM = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    input  logic fail,
    input  logic done,
    output logic allow,
    output logic [$clog2(BO_CAP_S+1)-1:0] bo_s,
    output logic [$clog2(TOK_MAX+1)-1:0]  tokens
);
    localparam int WIN_S = WIN_MIN * 60;
    localparam int AGE_W = $clog2(WIN_S);
    localparam int BO_W  = $clog2(BO_CAP_S + 1);
    localparam int TOK_W = $clog2(TOK_MAX + 1);
    localparam int CNT_W = $clog2(WIN_CAP + 1);

    // ---------------- backoff ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bo_s <= BO_W'(1);
        else if (done)
            bo_s <= BO_W'(1);
        else if (fail) begin
            if (int'(bo_s) * 2 >= BO_CAP_S)
                bo_s <= BO_W'(BO_CAP_S);
            else
                bo_s <= bo_s << 1;
        end
    end

    // ---------------- token bucket ----------------
    logic [6:0] acc;
    logic [7:0] acc_sum;
    logic       refill;
    int         tok_nxt;

    always_comb begin
        acc_sum = {1'b0, acc} + 8'(REFILL_PM);
        refill  = tick && (acc_sum >= 8'd60);
        tok_nxt = int'(tokens) + (refill ? 1 : 0) - (take ? TOK_COST : 0);
        if (tok_nxt > TOK_MAX) tok_nxt = TOK_MAX;
        if (tok_nxt < 0)       tok_nxt = 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            tokens <= TOK_W'(TOK_MAX);
        end else begin
            if (tick) acc <= refill ? 7'(acc_sum - 8'd60) : acc_sum[6:0];
            tokens <= TOK_W'(tok_nxt);
        end
    end

    // ---------------- sliding attempt window ----------------
    logic [WIN_CAP-1:0] vld;
    logic [AGE_W-1:0]   age     [WIN_CAP];
    logic [WIN_CAP-1:0] vld_aged;
    logic [AGE_W-1:0]   age_aged[WIN_CAP];
    logic [CNT_W-1:0]   used;

    for (genvar i = 0; i < WIN_CAP; i++) begin : g_slot
        always_comb begin
            vld_aged[i] = vld[i];
            age_aged[i] = age[i];
            if (tick && vld[i]) begin
                if (age[i] == AGE_W'(WIN_S - 1)) vld_aged[i] = 1'b0;
                else                             age_aged[i] = age[i] + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                age[i] <= '0;
            end else if (take) begin
                if (i == 0) begin
                    vld[i] <= 1'b1;
                    age[i] <= '0;
                end else begin
                    vld[i] <= vld_aged[i-1];
                    age[i] <= age_aged[i-1];
                end
            end else begin
                vld[i] <= vld_aged[i];
                age[i] <= age_aged[i];
            end
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < WIN_CAP; i++) used = used + CNT_W'(vld[i]);
        allow = (used < CNT_W'(WIN_CAP)) && (tokens >= TOK_W'(TOK_COST));
    end

    // R4: bucket never above its depth
    p_tok_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tokens <= TOK_W'(TOK_MAX));
    // R4: an attempt always leaves fewer or equal tokens
    p_take_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tokens <= $past(tokens));
    // R2: backoff stays within 1..cap and never shrinks on failure
    p_bo_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_s != '0) && (bo_s <= BO_W'(BO_CAP_S)));
    p_bo_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> bo_s >= $past(bo_s));

endmodule

// File: rtl/link_recovery_seq.sv
module link_recovery_seq
    import lrs_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int TEMP_OK   = 90,
    parameter int WAIT_S    = 5,
    parameter int HOLD_S    = 3,
    parameter int BO_CAP_S  = 8,
    parameter int WIN_MIN   = 1,
    parameter int WIN_CAP   = 3,
    parameter int TOK_MAX   = 4,
    parameter int TOK_COST  = 2,
    parameter int REFILL_PM = 6,
    parameter int OBS_S     = 2,
    parameter int LIM_S     = 2,
    parameter int STABLE_S  = 10,
    parameter int ERR_W     = 8,
    parameter int RETRY_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_1s,
    input  logic [TEMP_W-1:0]              temp_code,
    input  logic                           temp_rising,
    input  logic                           bus_off,
    input  logic                           thermal_evt,
    input  logic [ERR_W-1:0]               err_cnt,
    output logic                           speed_low,
    output logic                           drive_low,
    output logic                           listen_only,
    output logic                           isolate,
    output logic                           tx_en,
    output logic                           tx_limited,
    output logic [2:0]                     state_code,
    output logic [2:0]                     level,
    output logic [RETRY_W-1:0]             retry_idx,
    output logic [$clog2(BO_CAP_S+1)-1:0]  backoff_s,
    output logic [$clog2(TOK_MAX+1)-1:0]   tokens
);
    localparam int SEC_W  = 16;
    localparam int STAB_W = $clog2(STABLE_S + 1);
    localparam int BO_W   = $clog2(BO_CAP_S + 1);

    rec_state_e         st, st_nxt;
    logic [SEC_W-1:0]   sec_cnt;
    logic [ERR_W-1:0]   err_base, err_prev;
    logic [STAB_W-1:0]  stab_cnt;
    logic [2:0]         lvl;
    logic [RETRY_W-1:0] retry;
    logic               gate_pass, allow, take, fail, done, err_up;
    logic [BO_W-1:0]    bo_s;

    lrs_cool_gate #(
        .TEMP_W(TEMP_W), .TEMP_OK(TEMP_OK), .WAIT_S(WAIT_S), .HOLD_S(HOLD_S)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .en(st == ST_COOLING), .tick(tick_1s),
        .temp(temp_code), .rising(temp_rising), .pass(gate_pass)
    );

    lrs_rate_limiter #(
        .BO_CAP_S(BO_CAP_S), .WIN_MIN(WIN_MIN), .WIN_CAP(WIN_CAP),
        .TOK_MAX(TOK_MAX), .TOK_COST(TOK_COST), .REFILL_PM(REFILL_PM)
    ) u_lim (
        .clk(clk), .rst_n(rst_n), .tick(tick_1s), .take(take), .fail(fail),
        .done(done), .allow(allow), .bo_s(bo_s), .tokens(tokens)
    );

    // -------- next-state logic --------
    always_comb begin
        err_up = err_cnt > err_prev;
        fail   = ((st == ST_OBSERVE) || (st == ST_LIMITED)) &&
                 (bus_off || (err_cnt > err_base));
        take   = (st == ST_BACKOFF) && (sec_cnt >= SEC_W'(bo_s)) && allow;
        st_nxt = st;
        unique case (st)
            ST_ONLINE:   if (bus_off || thermal_evt) st_nxt = ST_COOLING;
            ST_COOLING:  if (gate_pass) st_nxt = ST_BACKOFF;
            ST_BACKOFF:  if (take) st_nxt = ST_OBSERVE;
            ST_OBSERVE: begin
                if (fail)
                    st_nxt = (lvl == LVL_LISTEN) ? ST_ISOLATED : ST_BACKOFF;
                else if (sec_cnt >= SEC_W'(OBS_S))
                    st_nxt = ST_LIMITED;
            end
            ST_LIMITED: begin
                if (fail)
                    st_nxt = (lvl == LVL_LISTEN) ? ST_ISOLATED : ST_BACKOFF;
                else if (sec_cnt >= SEC_W'(LIM_S))
                    st_nxt = ST_ONLINE;
            end
            ST_ISOLATED: st_nxt = ST_ISOLATED;
            default:     st_nxt = ST_ONLINE;
        endcase
        done = (st == ST_LIMITED) && (st_nxt == ST_ONLINE);
    end

    // -------- state register --------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ONLINE;
        else        st <= st_nxt;
    end

    // -------- timers, ladder, baseline --------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_cnt  <= '0;
            err_base <= '0;
            err_prev <= '0;
            stab_cnt <= '0;
            lvl      <= LVL_FULL;
            retry    <= '0;
        end else begin
            err_prev <= err_cnt;
            if (st_nxt != st)
                sec_cnt <= '0;
            else if (tick_1s && (sec_cnt != '1))
                sec_cnt <= sec_cnt + 1'b1;

            if (take) err_base <= err_cnt;

            if (fail) begin
                lvl <= lvl + 1'b1;
                if (retry != '1) retry <= retry + 1'b1;
            end else if (done) begin
                retry <= '0;
            end

            if ((st != ST_ONLINE) || err_up)
                stab_cnt <= '0;
            else if (tick_1s) begin
                if (stab_cnt == STAB_W'(STABLE_S - 1)) begin
                    stab_cnt <= '0;
                    if ((lvl != LVL_FULL) && (lvl != LVL_OFF)) lvl <= lvl - 1'b1;
                end else begin
                    stab_cnt <= stab_cnt + 1'b1;
                end
            end
        end
    end

    // -------- outputs --------
    always_comb begin
        speed_low   = (lvl >= LVL_SLOW) && (lvl != LVL_OFF);
        drive_low   = (lvl >= LVL_WEAK) && (lvl != LVL_OFF);
        listen_only = (lvl == LVL_LISTEN);
        isolate     = (lvl == LVL_OFF);
        tx_en       = ((st == ST_ONLINE) || (st == ST_LIMITED)) && (lvl < LVL_LISTEN);
        tx_limited  = (st == ST_LIMITED);
        state_code  = st;
        level       = lvl;
        retry_idx   = retry;
        backoff_s   = bo_s;
    end

    // R10: isolation is terminal
    p_isolated_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISOLATED) |=> (st == ST_ISOLATED) && (lvl == LVL_OFF));
    // R8: bus-off during rejoin never leaves the node in a rejoin stage
    p_abort_on_busoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OBSERVE) || (st == ST_LIMITED)) && bus_off |=>
        (st == ST_BACKOFF) || (st == ST_ISOLATED));
    // R7: limited transmit is only reached from silent observe
    p_rejoin_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LIMITED) && ($past(st) != ST_LIMITED) |-> $past(st) == ST_OBSERVE);
    // R5: each failure moves the ladder exactly one step down
    p_ladder_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> lvl == $past(lvl) + 3'd1);
    // R3: admitted attempts always respect the limiter
    p_take_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OBSERVE) && ($past(st) == ST_BACKOFF) |-> $past(allow));

endmodule

// File: tb/tb_link_recovery_seq.sv
module tb_link_recovery_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic [7:0] temp_code = 8'd60;
    logic       temp_rising = 1'b0;
    logic       bus_off = 1'b0;
    logic       thermal_evt = 1'b0;
    logic [7:0] err_cnt = 8'd0;
    logic       speed_low, drive_low, listen_only, isolate, tx_en, tx_limited;
    logic [2:0] state_code, level;
    logic [3:0] retry_idx, backoff_s;
    logic [2:0] tokens;

    int checks = 0;
    int errors = 0;

    localparam int S_ON = 0, S_COOL = 1, S_BO = 2, S_OBS = 3, S_LIM = 4, S_ISO = 5;

    always #10 clk = ~clk;

    link_recovery_seq dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .temp_code(temp_code),
        .temp_rising(temp_rising), .bus_off(bus_off), .thermal_evt(thermal_evt),
        .err_cnt(err_cnt), .speed_low(speed_low), .drive_low(drive_low),
        .listen_only(listen_only), .isolate(isolate), .tx_en(tx_en),
        .tx_limited(tx_limited), .state_code(state_code), .level(level),
        .retry_idx(retry_idx), .backoff_s(backoff_s), .tokens(tokens)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; err_cnt = 8'd0; temp_code = 8'd60; temp_rising = 1'b0;
        bus_off = 1'b0; thermal_evt = 1'b0; tick_1s = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1s = 1'b1;
            @(negedge clk) tick_1s = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse_bus_off();
        @(negedge clk) bus_off = 1'b1;
        @(negedge clk) bus_off = 1'b0;
        settle();
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R9", "reset state", state_code, S_ON);
        check("R9", "reset level", level, 0);
        check("R9", "reset tx_en", tx_en, 1);
        check("R4", "reset tokens", tokens, 4);
        check("R2", "reset backoff", backoff_s, 1);
        check("R5", "reset retry", retry_idx, 0);
    endtask

    task automatic t_timed_gate_and_rejoin();
        do_reset();
        temp_code = 8'd120; temp_rising = 1'b1;
        pulse_bus_off();
        check("R9", "bus_off -> cooling", state_code, S_COOL);
        check("R9", "tx off in cooling", tx_en, 0);
        tick(7);
        check("R1", "hot gate holds at 7 ticks", state_code, S_COOL);
        tick(1);
        check("R1", "timed gate opens at 8 ticks", state_code, S_BO);
        tick(1);
        check("R7", "attempt enters observe", state_code, S_OBS);
        check("R4", "attempt costs 2 tokens", tokens, 2);
        check("R7", "silent during observe", tx_en, 0);
        tick(2);
        check("R7", "observe -> limited", state_code, S_LIM);
        check("R7", "limited tx_en", tx_en, 1);
        check("R7", "limited flag", tx_limited, 1);
        tick(1);
        check("R7", "limited dwell", state_code, S_LIM);
        tick(1);
        check("R7", "limited -> online", state_code, S_ON);
        check("R7", "limited flag clear", tx_limited, 0);
    endtask

    task automatic t_ladder_and_limits();
        do_reset();
        pulse_bus_off();
        check("R1", "cool temp opens gate at once", state_code, S_BO);
        tick(1);
        check("R7", "first attempt", state_code, S_OBS);
        err_cnt = 8'd5;
        settle();
        check("R8", "error rise aborts", state_code, S_BO);
        check("R5", "level 1", level, 1);
        check("R5", "speed_low at level 1", speed_low, 1);
        check("R5", "drive_low off at level 1", drive_low, 0);
        check("R2", "backoff doubles to 2", backoff_s, 2);
        check("R5", "retry 1", retry_idx, 1);
        tick(1);
        check("R2", "backoff 2 holds after 1 tick", state_code, S_BO);
        tick(1);
        check("R2", "attempt after 2 ticks", state_code, S_OBS);
        check("R4", "tokens drained", tokens, 0);
        pulse_bus_off();
        check("R8", "bus_off aborts", state_code, S_BO);
        check("R5", "level 2 drive_low", drive_low, 1);
        check("R2", "backoff 4", backoff_s, 4);
        tick(4);
        check("R4", "empty bucket blocks", state_code, S_BO);
        tick(3);
        check("R4", "one token at tick 10", tokens, 1);
        check("R4", "still blocked", state_code, S_BO);
        tick(10);
        check("R4", "refill admits at tick 20", state_code, S_OBS);
        check("R4", "tokens after third attempt", tokens, 0);
        err_cnt = 8'd6;
        settle();
        check("R5", "listen_only at level 3", listen_only, 1);
        check("R2", "backoff 8", backoff_s, 8);
        check("R5", "retry 3", retry_idx, 3);
        tick(20);
        check("R3", "window cap blocks at tick 40", state_code, S_BO);
        check("R4", "tokens 2 at tick 40", tokens, 2);
        tick(20);
        check("R3", "still blocked at tick 60", state_code, S_BO);
        check("R4", "bucket saturates at 4", tokens, 4);
        tick(1);
        check("R3", "oldest attempt expires at tick 61", state_code, S_OBS);
        err_cnt = 8'd7;
        settle();
        check("R10", "failure at level 3 isolates", state_code, S_ISO);
        check("R5", "isolate flag", isolate, 1);
        check("R5", "tx off isolated", tx_en, 0);
        check("R2", "backoff capped at 8", backoff_s, 8);
        pulse_bus_off();
        tick(5);
        check("R10", "isolation sticky", state_code, S_ISO);
    endtask

    task automatic t_stepup_and_baseline();
        do_reset();
        pulse_bus_off();
        tick(1);
        tick(2);
        check("R7", "reached limited", state_code, S_LIM);
        err_cnt = 8'd3;
        settle();
        check("R8", "error rise in limited aborts", state_code, S_BO);
        check("R5", "level 1 after abort", level, 1);
        tick(2);
        check("R7", "second attempt", state_code, S_OBS);
        tick(2);
        check("R7", "baseline tolerates old count", state_code, S_LIM);
        tick(2);
        check("R7", "rejoin complete", state_code, S_ON);
        check("R2", "backoff reset on success", backoff_s, 1);
        check("R5", "retry reset on success", retry_idx, 0);
        check("R7", "tx_en online level 1", tx_en, 1);
        tick(9);
        check("R6", "level held at 9 ticks", level, 1);
        err_cnt = 8'd4;
        settle();
        tick(9);
        check("R6", "error restarts window", level, 1);
        tick(1);
        check("R6", "step up after 10 clean ticks", level, 0);
    endtask

    task automatic t_slope_gate();
        do_reset();
        temp_code = 8'd100; temp_rising = 1'b0;
        @(negedge clk) thermal_evt = 1'b1;
        @(negedge clk) thermal_evt = 1'b0;
        settle();
        check("R9", "thermal event -> cooling", state_code, S_COOL);
        temp_code = 8'd60; temp_rising = 1'b1;
        settle();
        check("R1", "rising slope blocks gate", state_code, S_COOL);
        temp_rising = 1'b0;
        settle();
        check("R1", "cool and falling opens gate", state_code, S_BO);
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_timed_gate_and_rejoin();
        t_ladder_and_limits();
        t_stepup_and_baseline();
        t_slope_gate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule